// File: doc/BRIEF.md
# Clock wake-up and divider controller

This block sits on the raw oscillator clock and decides when the rest of the chip may run. After a reset, or after a wake request that brings the chip out of power-down, it holds the CPU and peripheral clock enables low and the ready flag deasserted. The hold lasts for a stabilisation delay whose length depends on the selected clock source. Crystal sources need a long cycle count plus a settling interval. The on-chip RC source needs a pure time interval. The fast-starting sources need only a short fixed count. Time intervals are turned into oscillator cycles through the parameter `CYC_PER_US`, and the top of each allowed range is used, so every delay is exact.

Once ready, the block produces a one-cycle CPU clock enable every 2×N oscillator cycles, where N is an 8-bit divide value written through the register port. N = 0 gives an enable on every cycle. Software may rewrite N at any time. The new value waits in a pending register and is adopted only when the current enable period ends, so no period is ever cut short or stretched. A peripheral enable fires on every second CPU enable. A low-power select bit sits on the same write port. It clears on reset and changes only through an explicit write.

Top module: `clk_wake_div`

## Requirements
- R1: With `src_sel` 0, 1 or 2 (crystal sources) sampled on the first rising edge after reset release, `ready` is first high after rising edge number 1025 + 100×CYC_PER_US counted from that release, that is, after a delay D = 1024 + 100×CYC_PER_US followed by one edge.
- R2: With `src_sel` 3 (RC source) the same count is D + 1 with D = 300×CYC_PER_US.
- R3: With `src_sel` 4 to 7 (watchdog oscillator, external clock, unused codes) the count is D + 1 with D = 32.
- R4: While `ready` is low, `cpu_ce` and `per_ce` are low.
- R5: While ready and with active divide value N, `cpu_ce` pulses for one cycle every 2×N cycles, or on every cycle when N = 0.
- R6: A divide write (`wr_en`=1, `wr_sel`=0, value `wr_data`) made inside an enable period leaves that period at its old length; the next period has the new length.
- R7: `per_ce` is high only together with `cpu_ce`, on the first `cpu_ce` after `ready` rises and on every second one after that, so its period is twice the CPU period.
- R8: `lp_mode` is 0 during and after reset, is set to `wr_data[0]` by a write with `wr_sel`=1, and is not changed by divide writes or wake requests.
- R9: A `wake_req` sampled high while ready drops `ready` on that edge and restarts the delay for the `src_sel` value sampled on the next edge; `ready` returns after D + 1 edges.
- R10: A `wake_req` while the delay is running is ignored: the total delay is unchanged.
- R11: The divide value is 0 after reset, and a value written while gated is used from the first `cpu_ce` after `ready` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Raw oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_req | input | 1 | Wake from power-down; restarts the delay when ready |
| src_sel | input | 3 | Clock source code: 0-2 crystal, 3 RC, 4-7 fast start |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 divide value, 1 low-power bit |
| wr_data | input | 8 | Write data |
| cpu_ce | output | 1 | CPU clock enable pulse |
| per_ce | output | 1 | Peripheral clock enable pulse, half the CPU rate |
| ready | output | 1 | Clock stable, enables released |
| lp_mode | output | 1 | Low-power select bit |

## Verification
The bench resets into every source code and counts edges to the rise of `ready`. An off-by-one in the counter load or the wrong delay table entry shows up as a wrong count, and an enable leaking out early shows up during the count. It sweeps divide values, including 0 and 255, and measures pulse gaps. A ratio of N or 2N+1, or a divide value of 0 that stalls, shows up as a wrong gap. Retune writes land in mid-period: a design that adopts the value at once gives a shortened or stretched gap. Wakes during the delay, and writes to one register target, are checked to leave the delay and the other register alone.

// File: rtl/clk_wake_div.sv
`timescale 1ns/1ps
module clk_wake_div #(
  parameter int CYC_PER_US = 4,
  parameter int DIV_W      = 8
) (
  input  logic             osc_clk,
  input  logic             rst_n,
  input  logic             wake_req,
  input  logic [2:0]       src_sel,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [DIV_W-1:0] wr_data,
  output logic             cpu_ce,
  output logic             per_ce,
  output logic             ready,
  output logic             lp_mode
);
  localparam int XTAL_D = 1024 + 100 * CYC_PER_US;
  localparam int RC_D   = 300 * CYC_PER_US;
  localparam int FAST_D = 32;
  localparam int MAX_D  = (XTAL_D > RC_D) ? XTAL_D : RC_D;
  localparam int CNT_W  = $clog2(MAX_D + 1);
  localparam int DC_W   = DIV_W + 1;

  typedef enum logic [1:0] {ST_START, ST_WAIT, ST_RUN} st_t;

  st_t              state;
  logic [CNT_W-1:0] cnt, dly_m1;
  logic [DIV_W-1:0] div_pend, div_act;
  logic [DC_W-1:0]  dcnt, ratio;
  logic             ph, last;

  always_comb begin
    case (src_sel)
      3'd0, 3'd1, 3'd2: dly_m1 = CNT_W'(XTAL_D - 1);
      3'd3:             dly_m1 = CNT_W'(RC_D - 1);
      default:          dly_m1 = CNT_W'(FAST_D - 1);
    endcase
  end

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_START;
      cnt   <= '0;
    end else begin
      case (state)
        ST_START: begin
          cnt   <= dly_m1;
          state <= ST_WAIT;
        end
        ST_WAIT:
          if (cnt == '0) state <= ST_RUN;
          else           cnt   <= cnt - 1'b1;
        default:
          if (wake_req) state <= ST_START;
      endcase
    end
  end

  assign ready  = (state == ST_RUN);
  assign ratio  = (div_act == '0) ? DC_W'(1) : {div_act, 1'b0};
  assign last   = (dcnt == ratio - 1'b1);
  assign cpu_ce = ready && (dcnt == '0);
  assign per_ce = cpu_ce && !ph;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      div_pend <= '0;
      lp_mode  <= 1'b0;
    end else if (wr_en) begin
      if (wr_sel) lp_mode  <= wr_data[0];
      else        div_pend <= wr_data;
    end
  end

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt    <= '0;
      div_act <= '0;
      ph      <= 1'b0;
    end else if (!ready) begin
      dcnt    <= '0;
      div_act <= div_pend;
      ph      <= 1'b0;
    end else begin
      if (last) begin
        dcnt    <= '0;
        div_act <= div_pend;
      end else begin
        dcnt <= dcnt + 1'b1;
      end
      if (cpu_ce) ph <= ~ph;
    end
  end
endmodule

module clk_wake_div_chk #(
  parameter int DIV_W = 8,
  parameter int CNT_W = 12
) (
  input logic             osc_clk,
  input logic             rst_n,
  input logic             wake_req,
  input logic             wr_en,
  input logic             wr_sel,
  input logic             cpu_ce,
  input logic             per_ce,
  input logic             ready,
  input logic             lp_mode,
  input logic             in_wait,
  input logic [CNT_W-1:0] cnt,
  input logic [DIV_W-1:0] div_act,
  input logic [DIV_W:0]   dcnt,
  input logic [DIV_W:0]   ratio
);
  logic seen, prev_per;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      seen     <= 1'b0;
      prev_per <= 1'b0;
    end else if (!ready) begin
      seen <= 1'b0;
    end else if (cpu_ce) begin
      seen     <= 1'b1;
      prev_per <= per_ce;
    end
  end

  // R9
  ready_hold_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    ready && !wake_req |=> ready);

  // R10
  wait_count_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    in_wait && $past(in_wait) |-> cnt == CNT_W'($past(cnt) - 1'b1));

  // R6
  div_swap_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    !$stable(div_act) |-> $past(!ready || (dcnt == ratio - 1'b1)));

  // R8
  lp_write_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    !$stable(lp_mode) |-> $past(wr_en && wr_sel));

  // R7
  per_alt_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    cpu_ce && seen |-> per_ce != prev_per);

  // R7
  per_first_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    $rose(ready) |-> per_ce);
endmodule

bind clk_wake_div clk_wake_div_chk #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_chk (
  .osc_clk(osc_clk), .rst_n(rst_n), .wake_req(wake_req), .wr_en(wr_en),
  .wr_sel(wr_sel), .cpu_ce(cpu_ce), .per_ce(per_ce), .ready(ready),
  .lp_mode(lp_mode), .in_wait(state == ST_WAIT), .cnt(cnt),
  .div_act(div_act), .dcnt(dcnt), .ratio(ratio)
);

// File: tb/test_clk_wake_div.sv
`timescale 1ns/1ps
module test_clk_wake_div;
  localparam int CPU = 4;
  localparam int XD  = 1024 + 100 * CPU;
  localparam int RD  = 300 * CPU;
  localparam int FD  = 32;

  logic osc_clk = 1'b0;
  logic rst_n = 1'b0, wake_req = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
  logic [2:0] src_sel = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic cpu_ce, per_ce, ready, lp_mode;
  int tests = 0, fails = 0, cyc = 0;

  always #2 osc_clk = ~osc_clk;

  clk_wake_div #(.CYC_PER_US(CPU), .DIV_W(8)) i_clk_wake_div (
    .osc_clk(osc_clk), .rst_n(rst_n), .wake_req(wake_req), .src_sel(src_sel),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .cpu_ce(cpu_ce),
    .per_ce(per_ce), .ready(ready), .lp_mode(lp_mode));

  always @(posedge osc_clk) begin
    cyc++;
    if (cyc > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog: act %0d cycles exp fewer than 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act %0d exp %0d", tag, act, exp);
    end
  endtask

  function automatic int dly(input int s);
    if (s <= 2) return XD;
    if (s == 3) return RD;
    return FD;
  endfunction

  task automatic tick();
    @(posedge osc_clk); #1;
  endtask

  task automatic wait_ready(input int wake_at, output int n, output bit leak);
    n = 0; leak = 0;
    while (!ready && n < 5000) begin
      if (n == wake_at) wake_req = 1'b1;
      tick();
      wake_req = 1'b0;
      n++;
      if (!ready && (cpu_ce || per_ce)) leak = 1;
    end
  endtask

  task automatic do_reset(input int s, input string tag);
    int n; bit leak;
    @(negedge osc_clk);
    rst_n = 1'b0; src_sel = 3'(s);
    @(negedge osc_clk); @(negedge osc_clk);
    check(!ready && !cpu_ce && !per_ce && !lp_mode, "R4/R8 reset state", {ready, cpu_ce, per_ce, lp_mode}, 0);
    rst_n = 1'b1;
    wait_ready(-1, n, leak);
    check(n == dly(s) + 1, tag, n, dly(s) + 1);
    check(!leak, "R4 gated during delay", leak, 0);
  endtask

  task automatic wr(input bit sel, input int d);
    wr_en = 1'b1; wr_sel = sel; wr_data = 8'(d);
    tick();
    wr_en = 1'b0;
  endtask

  task automatic wait_ce();
    int g = 0;
    do begin tick(); g++; end while (!cpu_ce && g < 2000);
  endtask

  task automatic gap(input bit per, output int g);
    g = 0;
    do begin tick(); g++; end while (!(per ? per_ce : cpu_ce) && g < 2000);
  endtask

  initial begin
    int g, g2, n, ex; bit leak;
    int divs[8] = '{0, 1, 2, 3, 7, 40, 127, 255};

    for (int s = 0; s < 8; s++) begin
      if (s <= 2)      do_reset(s, "R1 crystal delay");
      else if (s == 3) do_reset(s, "R2 RC delay");
      else             do_reset(s, "R3 fast delay");
    end
    check(cpu_ce && per_ce, "R7 first pulses at ready", {cpu_ce, per_ce}, 3);
    gap(1'b0, g);
    check(g == 1, "R11 divide 0 after reset", g, 1);

    foreach (divs[i]) begin
      ex = (divs[i] == 0) ? 1 : 2 * divs[i];
      wr(1'b0, divs[i]);
      wait_ce(); wait_ce();
      gap(1'b0, g); gap(1'b0, g2);
      check(g == ex && g2 == ex, "R5 cpu_ce period", g, ex);
      wait_ce();
      while (!per_ce) wait_ce();
      gap(1'b1, g);
      check(g == 2 * ex, "R7 per_ce period", g, 2 * ex);
    end

    wr(1'b0, 3); wait_ce(); wait_ce();
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'd1;
    g = 0;
    do begin tick(); wr_en = 1'b0; g++; end while (!cpu_ce && g < 2000);
    gap(1'b0, g2);
    check(g == 6, "R6 period holds on retune down", g, 6);
    check(g2 == 2, "R6 next period uses new value", g2, 2);

    wr(1'b0, 2); wait_ce(); wait_ce();
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'd5;
    g = 0;
    do begin tick(); wr_en = 1'b0; g++; end while (!cpu_ce && g < 2000);
    gap(1'b0, g2);
    check(g == 4 && g2 == 10, "R6 retune up", g * 100 + g2, 410);

    wr(1'b1, 1);
    check(lp_mode == 1'b1, "R8 lp set by write", lp_mode, 1);
    wr(1'b0, 8'h02);
    check(lp_mode == 1'b1, "R8 divide write leaves lp", lp_mode, 1);

    src_sel = 3'd5;
    wake_req = 1'b1; tick(); wake_req = 1'b0;
    check(!ready && !cpu_ce, "R9 wake drops ready", {ready, cpu_ce}, 0);
    wait_ready(-1, n, leak);
    check(n == FD + 1, "R9 wake delay", n, FD + 1);
    check(lp_mode == 1'b1, "R8 wake leaves lp", lp_mode, 1);

    src_sel = 3'd3;
    wake_req = 1'b1; tick(); wake_req = 1'b0;
    wr(1'b0, 3);
    wait_ready(100, n, leak);
    n = n + 1;
    check(n == RD + 1, "R10 wake during delay ignored", n, RD + 1);
    check(!leak, "R4 gated after wake", leak, 0);
    gap(1'b0, g);
    check(g == 6, "R11 gated write used from first pulse", g, 6);

    wr(1'b1, 0);
    check(lp_mode == 1'b0, "R8 lp cleared by write", lp_mode, 0);
    wr(1'b1, 1);
    do_reset(4, "R3 fast delay after lp set");
    check(lp_mode == 1'b0, "R8 lp 0 after reset", lp_mode, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule